// File: doc/BRIEF.md
# Non-Posted Credit Grant Generator

This block sits on the consumer side of a request path and tells an upstream request source how many read (non-posted) requests it may send. When reset is released it hands out a fixed baseline of credits. From then on it returns exactly one credit for every non-posted request it accepts, so the number of reads the source may have in flight stays at the baseline. A larger baseline hides the round-trip delay between accepting a read and the source seeing the returned credit, and this raises read throughput. Useful baselines are 2, 4 and 8.

Credits go out on a 2-bit count output that can carry zero, one or two credits per cycle. Baseline credits are sent first, two per cycle. An odd baseline ends with a single credit. Replenish credits that cannot leave at once wait in a pending counter, and they fill any slot the baseline leaves unused. Posted (write) requests also pass through the accept strobe, but they earn no credit.

Top module: `np_credit_gen`

## Requirements
- R1: While `rst_ni` is low, `grant_o` is 00. Each reset release clears all owed replenish credits and starts the baseline issue again.
- R2: `grant_o` encodes a credit count: 00 is none, 01 is one credit, 10 is two credits. The value 11 never appears.
- R3: From the first rising edge after reset release, the baseline of `BASE_CREDITS` credits is issued two per cycle. If one credit remains it goes out as a single grant in the last baseline cycle. With the default baseline of 2, a single grant of 10 follows reset and then 00.
- R4: A non-posted request (`req_valid_i`=1, `req_np_i`=1) sampled at rising edge k gives one credit on `grant_o` after edge k+1, and not after edge k.
- R5: A posted request (`req_valid_i`=1, `req_np_i`=0) produces no credit.
- R6: Replenish credits that fall due while baseline credits are still being issued wait until the baseline has been served. Baseline and pending credits share a cycle when the baseline leaves room, for at most two in total.
- R7: Each cycle the grant equals the lesser of two and the credits still owed. No cycle is left idle while credits are owed.
- R8: For a source that never sends a read without a credit, credits granted minus reads accepted never exceeds `BASE_CREDITS`, which is at most 32.
- R9: Once the block is idle, total credits granted since reset minus non-posted requests accepted equals `BASE_CREDITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Strobe: a request was accepted this cycle |
| req_np_i | input | 1 | Class of the accepted request: 1 non-posted, 0 posted |
| grant_o | output | 2 | Credits granted this cycle: 00 none, 01 one, 10 two |

## Verification
The bench runs the default baseline of 2 and an odd baseline of 5 side by side on the same stimulus. This shows the two-per-cycle baseline, the final single grant, and the mixing of a leftover baseline credit with a pending replenish credit. A design that drops that mix would emit 01 where 10 is due, and the grant totals would then come out short. Replenish latency is checked at the exact cycle, so a design that bypasses the pending register, or adds one too many, is caught. Posted requests and a reset that lands while a replenish is owed both test that no stray credit appears. A design that leaked one would break the idle balance of granted minus accepted equal to the baseline.

// File: rtl/np_credit_pkg.sv
package np_credit_pkg;
  localparam int unsigned GRANT_W = 2;

  typedef enum logic [GRANT_W-1:0] {
    GRANT_NONE = 2'b00,
    GRANT_ONE  = 2'b01,
    GRANT_TWO  = 2'b10
  } grant_e;

  // clamp a credit count to the two a single grant can carry
  function automatic logic [GRANT_W-1:0] clamp2(input int unsigned n);
    return (n >= 2) ? 2'd2 : GRANT_W'(n);
  endfunction
endpackage

// File: rtl/np_base_issuer.sv
module np_base_issuer
  import np_credit_pkg::*;
#(
  parameter int unsigned BASE_CREDITS = 2,
  parameter int unsigned CNT_W        = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [GRANT_W-1:0] take_o
);
  logic [CNT_W-1:0] left_q;

  // baseline always has priority, so whatever is offered is consumed
  assign take_o = clamp2(32'(left_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= CNT_W'(BASE_CREDITS);
    else         left_q <= left_q - CNT_W'(take_o);
  end
endmodule

// File: rtl/np_replenish_ctr.sv
module np_replenish_ctr
  import np_credit_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic [GRANT_W-1:0] take_i,
  output logic [CNT_W-1:0]   avail_o
);
  logic [CNT_W-1:0] pend_q;

  assign avail_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_q + CNT_W'(inc_i) - CNT_W'(take_i);
  end
endmodule

// File: rtl/np_grant_merge.sv
module np_grant_merge
  import np_credit_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GRANT_W-1:0] base_take_i,
  input  logic [CNT_W-1:0]   pend_avail_i,
  output logic [GRANT_W-1:0] pend_take_o,
  output logic [GRANT_W-1:0] grant_o
);
  logic [GRANT_W-1:0] room;
  logic [GRANT_W-1:0] grant_q;

  always_comb begin
    room        = 2'd2 - base_take_i;
    pend_take_o = (32'(pend_avail_i) >= 32'(room)) ? room : GRANT_W'(pend_avail_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_q <= GRANT_NONE;
    else         grant_q <= base_take_i + pend_take_o;
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/np_credit_gen.sv
module np_credit_gen
  import np_credit_pkg::*;
#(
  parameter int unsigned BASE_CREDITS = 2,
  parameter int unsigned MAX_CREDITS  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_np_i,
  output logic [GRANT_W-1:0] grant_o
);
  localparam int unsigned CNT_W = $clog2(MAX_CREDITS + 1) + 1;

  logic [GRANT_W-1:0] base_take;
  logic [GRANT_W-1:0] pend_take;
  logic [CNT_W-1:0]   pend_avail;
  logic               np_acc;

  assign np_acc = req_valid_i & req_np_i;

  np_base_issuer #(
    .BASE_CREDITS(BASE_CREDITS),
    .CNT_W       (CNT_W)
  ) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_o(base_take)
  );

  np_replenish_ctr #(
    .CNT_W(CNT_W)
  ) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (np_acc),
    .take_i (pend_take),
    .avail_o(pend_avail)
  );

  np_grant_merge #(
    .CNT_W(CNT_W)
  ) u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_take_i (base_take),
    .pend_avail_i(pend_avail),
    .pend_take_o (pend_take),
    .grant_o     (grant_o)
  );
endmodule

// File: rtl/np_credit_gen_chk.sv
module np_credit_gen_chk #(
  parameter int unsigned BASE_CREDITS = 2,
  parameter int unsigned MAX_CREDITS  = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_np_i,
  input logic [1:0] grant_o
);
  localparam int unsigned W = $clog2(MAX_CREDITS + 1) + 2;

  logic [W-1:0] owed_q;   // credits due but not yet seen on grant_o
  logic [W-1:0] outst_q;  // credits held by the source
  logic [W-1:0] remain;
  logic         np_acc;

  assign np_acc = req_valid_i & req_np_i;
  assign remain = owed_q - W'(grant_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q  <= W'(BASE_CREDITS);
      outst_q <= '0;
    end else begin
      owed_q  <= owed_q + W'(np_acc) - W'(grant_o);
      outst_q <= outst_q + W'(grant_o) - W'(np_acc);
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (grant_o == 2'b00);
  end

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o != 2'b11);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(outst_q) + 32'(grant_o)) <= BASE_CREDITS);

  assert_grant_two_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain >= W'(2)) |=> (grant_o == 2'b10));

  assert_grant_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain == W'(1)) |=> (grant_o == 2'b01));

  assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain == '0) |=> (grant_o == 2'b00));
endmodule

bind np_credit_gen np_credit_gen_chk #(
  .BASE_CREDITS(BASE_CREDITS),
  .MAX_CREDITS (MAX_CREDITS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_np_i   (req_np_i),
  .grant_o    (grant_o)
);

// File: tb/np_credit_gen_bench.sv
module np_credit_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_np = 1'b0;
  logic [1:0] g_main;
  logic [1:0] g_odd;

  int n_chk = 0;
  int n_err = 0;
  int tot_main = 0;
  int tot_odd = 0;
  int base_seen = 0;
  int np_cnt = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  np_credit_gen u_np_credit_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_np_i(req_np), .grant_o(g_main)
  );

  np_credit_gen #(.BASE_CREDITS(5)) u_np_credit_gen_odd (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_np_i(req_np), .grant_o(g_odd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic drive(input bit v, input bit np);
    req_valid = v;
    req_np    = np;
    if (v && np) begin
      exp_q.push_back(np_cnt);
      np_cnt++;
    end
  endtask

  // monitor: baseline credits first, then each credit must retire one queued read
  always @(negedge clk) begin
    if (!rst_n) begin
      tot_main  = 0;
      tot_odd   = 0;
      base_seen = 0;
      exp_q.delete();
    end else begin
      if (g_main == 2'b11) chk("R2 code", 3, 2);
      tot_main += int'(g_main);
      tot_odd  += int'(g_odd);
      for (int c = 0; c < int'(g_main); c++) begin
        if (base_seen < 2) base_seen++;
        else if (exp_q.size() == 0) chk("R5 unexpected credit", 1, 0);
        else void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL R9 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 reset main", g_main, 0);
    chk("R1 reset odd", g_odd, 0);
    rst_n = 1'b1;
    np_cnt = 0;
    step();
    chk("R3 base first main", g_main, 2);
    chk("R3 base first odd", g_odd, 2);
    step();
    chk("R3 base done main", g_main, 0);
    chk("R3 base second odd", g_odd, 2);
    step();
    chk("R3 odd final single", g_odd, 1);
    step();
    chk("R3 odd done", g_odd, 0);
    chk("R9 idle main", tot_main - np_cnt, 2);
    chk("R9 idle odd", tot_odd - np_cnt, 5);

    // posted request earns nothing
    drive(1, 0);
    step();
    drive(0, 0);
    chk("R5 posted", g_main, 0);
    step();
    chk("R5 posted", g_main, 0);
    step();
    chk("R5 posted main", g_main, 0);
    chk("R5 posted odd", g_odd, 0);
    chk("R5 total", tot_main, 2);

    // single read: credit two edges later
    drive(1, 1);
    step();
    drive(0, 0);
    chk("R4 not early", g_main, 0);
    step();
    chk("R4 replenish main", g_main, 1);
    chk("R4 replenish odd", g_odd, 1);
    step();
    chk("R4 single only", g_main, 0);
    chk("R9 after read", tot_main - np_cnt, 2);

    // reset while a replenish is owed
    drive(1, 1);
    step();
    drive(0, 0);
    rst_n = 1'b0;
    chk("R1 reset async", g_main, 0);
    step();
    chk("R1 reset held", g_main, 0);
    rst_n = 1'b1;
    np_cnt = 0;
    step();
    chk("R1 restart main", g_main, 2);
    chk("R1 restart odd", g_odd, 2);

    // reads overlapping the odd baseline
    drive(1, 1);
    step();
    chk("R6 main wait", g_main, 0);
    chk("R6 odd base", g_odd, 2);
    drive(1, 1);
    step();
    drive(0, 0);
    chk("R6 main replenish", g_main, 1);
    chk("R6 odd mixed pair", g_odd, 2);
    step();
    chk("R7 main", g_main, 1);
    chk("R6 odd leftover", g_odd, 1);
    step();
    chk("R7 idle main", g_main, 0);
    chk("R7 idle odd", g_odd, 0);
    chk("R9 overlap main", tot_main - np_cnt, 2);
    chk("R9 overlap odd", tot_odd - np_cnt, 5);

    // stream driven by the source's own credit view
    for (int i = 0; i < 80; i++) begin
      int credits;
      credits = tot_main - np_cnt;
      if (credits > 2) chk("R8 outstanding", credits, 2);
      if (i % 4 == 3)       drive(1, 0);
      else if (credits > 0) drive(1, 1);
      else                  drive(0, 0);
      step();
    end
    drive(0, 0);
    repeat (4) step();
    chk("R9 stream main", tot_main - np_cnt, 2);
    chk("R9 stream odd", tot_odd - np_cnt, 5);
    chk("R4 all retired", exp_q.size(), 0);
    chk("R8 stream progress", int'(np_cnt > 20), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule